// File: doc/BRIEF.md
# Page-Unit Hamming Check and Repair

This block decides whether a 512-byte data unit read from flash still matches the 24-bit Hamming code kept beside it, and repairs the data when that is possible. The caller gives it two codes. One is the code as stored in the spare area. The other is the code recomputed over the data just read. When start is raised, the block XORs the two codes into a syndrome and sorts that syndrome into one of four outcomes. The outcome appears on a 2-bit status output.

When the syndrome points at a single flipped data bit, the block works out the byte and bit location from the syndrome. It then repairs the attached 512-byte buffer in two steps: it reads the byte, and one cycle later writes it back with that one bit inverted. Stored codes that are all ones can optionally be treated as coming from an erased page, so that blank pages are not reported as faults.

Top module: `hamming_fix_unit`

## Requirements
- R1: The syndrome is stored XOR recomputed, byte 0 in bits 7:0, byte 1 in bits 15:8 and byte 2 in bits 23:16. An all-zero syndrome reports status 0 (clean) and makes no buffer access.
- R2: When `skip_erased` is 1 and the stored code is 24'hFFFFFF, status is 0 and the buffer is not written, whatever the syndrome is. When `skip_erased` is 0, the same codes are classified by the normal rules.
- R3: A syndrome counts as a correctable data error only if, in every bit pair (2k+1, 2k) for k = 0..11, exactly one of the two bits is set. A single pair that breaks this rule makes the syndrome not correctable.
- R4: The bit index is {syndrome[23], syndrome[21], syndrome[19]}, with syndrome[23] as the MSB.
- R5: The 9-bit byte index is built from the odd syndrome bits, MSB first: {syndrome[17], syndrome[15], syndrome[13], syndrome[11], syndrome[9], syndrome[7], syndrome[5], syndrome[3], syndrome[1]}.
- R6: A correctable error reports status 1. It asserts `buf_rd_en` for one cycle at the byte index. In the next cycle it asserts `buf_wr_en` at the same address, with the data `buf_rdata` XOR (1 << bit index). The buffer has a read latency of one cycle.
- R7: A syndrome with exactly one bit set reports status 2 and makes no buffer write.
- R8: Every other syndrome reports status 3 and makes no buffer write.
- R9: `done` is high for exactly one cycle. That cycle comes 3 cycles after the start edge for a correction (read, write, done), and 1 cycle after it otherwise. `status` keeps its value until the next operation.
- R10: `start` is ignored while `busy` is high.
- R11: After reset the block is idle: `busy`, `done`, `buf_rd_en` and `buf_wr_en` are 0, and `status` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a check; sampled only while idle |
| ecc_stored | input | 24 | Code read from the spare area |
| ecc_calc | input | 24 | Code recomputed over the data |
| skip_erased | input | 1 | Treat an all-ones stored code as clean |
| busy | output | 1 | An operation is in progress |
| done | output | 1 | One-cycle completion pulse |
| status | output | 2 | 0 clean, 1 corrected, 2 code-field error, 3 uncorrectable |
| buf_addr | output | 9 | Buffer byte address |
| buf_rd_en | output | 1 | Buffer read strobe |
| buf_rdata | input | 8 | Buffer read data, one cycle after `buf_rd_en` |
| buf_wr_en | output | 1 | Buffer write strobe |
| buf_wdata | output | 8 | Buffer write data |

## Verification
A random pair of codes almost never gives a correctable syndrome, because every one of the twelve bit pairs must hold exactly one set bit. The bench therefore builds each syndrome from a chosen byte and bit location: each odd bit carries one location bit and each even bit carries its complement. It then XORs that syndrome into an arbitrary recomputed code to get the stored code. The same construction, with one pair forced to 11, produces syndromes that fail the test by a single pair. To exercise the busy window, a second start is issued in the middle of a correction, and the bench shows that it produces neither a second completion nor a buffer access.

// File: rtl/hfix_pkg.sv
package hfix_pkg;
    localparam int BYTE_W     = 8;
    localparam int CODE_BYTES = 3;
    localparam int CODE_W     = BYTE_W * CODE_BYTES;
    localparam int PAIRS      = CODE_W / 2;
    localparam int ADDR_W     = 9;
    localparam int BITIX_W    = PAIRS - ADDR_W;

    typedef enum logic [1:0] {
        ST_CLEAN = 2'd0,
        ST_FIXED = 2'd1,
        ST_CODE  = 2'd2,
        ST_BAD   = 2'd3
    } hfix_status_e;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_READ,
        PH_WRITE,
        PH_FIN
    } hfix_phase_e;

    typedef struct packed {
        hfix_phase_e             phase;
        hfix_status_e            status;
        logic [ADDR_W-1:0]       addr;
        logic [BITIX_W-1:0]      bit_ix;
    } hfix_regs_t;
endpackage

// File: rtl/hfix_classify.sv
module hfix_classify
    import hfix_pkg::*;
(
    input  logic [CODE_W-1:0] ecc_stored,
    input  logic [CODE_W-1:0] ecc_calc,
    input  logic              skip_erased,
    output hfix_status_e      verdict,
    output logic [PAIRS-1:0]  odd_bits
);
    logic [CODE_W-1:0] syn;
    logic [PAIRS-1:0]  pair_ok;
    logic              erased;
    logic              single;

    assign syn    = ecc_stored ^ ecc_calc;
    assign erased = &ecc_stored;
    assign single = (syn != '0) && ((syn & (syn - 1'b1)) == '0);

    // Each pair of syndrome bits must differ for a data-bit fault.
    for (genvar p = 0; p < PAIRS; p++) begin : g_pair
        assign pair_ok[p]  = syn[2*p+1] ^ syn[2*p];
        assign odd_bits[p] = syn[2*p+1];
    end

    always_comb begin
        if (skip_erased && erased)  verdict = ST_CLEAN;
        else if (syn == '0)         verdict = ST_CLEAN;
        else if (&pair_ok)          verdict = ST_FIXED;
        else if (single)            verdict = ST_CODE;
        else                        verdict = ST_BAD;
    end
endmodule

// File: rtl/hfix_locate.sv
module hfix_locate
    import hfix_pkg::*;
(
    input  logic [PAIRS-1:0]   odd_bits,
    output logic [ADDR_W-1:0]  byte_ix,
    output logic [BITIX_W-1:0] bit_ix
);
    // Low odd bits give the byte address, the top ones the bit position.
    assign byte_ix = odd_bits[ADDR_W-1:0];
    assign bit_ix  = odd_bits[PAIRS-1:ADDR_W];
endmodule

// File: rtl/hamming_fix_unit.sv
module hamming_fix_unit
    import hfix_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic [23:0] ecc_stored,
    input  logic [23:0] ecc_calc,
    input  logic        skip_erased,
    output logic        busy,
    output logic        done,
    output logic [1:0]  status,
    output logic [8:0]  buf_addr,
    output logic        buf_rd_en,
    input  logic [7:0]  buf_rdata,
    output logic        buf_wr_en,
    output logic [7:0]  buf_wdata
);
    hfix_status_e        verdict;
    logic [PAIRS-1:0]    odd_bits;
    logic [ADDR_W-1:0]   byte_ix;
    logic [BITIX_W-1:0]  bit_ix;
    hfix_regs_t          r_d, r_q;

    hfix_classify u_cls (
        .ecc_stored  (ecc_stored),
        .ecc_calc    (ecc_calc),
        .skip_erased (skip_erased),
        .verdict     (verdict),
        .odd_bits    (odd_bits)
    );

    hfix_locate u_loc (
        .odd_bits (odd_bits),
        .byte_ix  (byte_ix),
        .bit_ix   (bit_ix)
    );

    always_comb begin
        r_d = r_q;
        unique case (r_q.phase)
            PH_IDLE: begin
                if (start) begin
                    r_d.status = verdict;
                    r_d.addr   = byte_ix;
                    r_d.bit_ix = bit_ix;
                    r_d.phase  = (verdict == ST_FIXED) ? PH_READ : PH_FIN;
                end
            end
            PH_READ:  r_d.phase = PH_WRITE;
            PH_WRITE: r_d.phase = PH_FIN;
            PH_FIN:   r_d.phase = PH_IDLE;
            default:  r_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.phase  <= PH_IDLE;
            r_q.status <= ST_CLEAN;
            r_q.addr   <= '0;
            r_q.bit_ix <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign busy      = (r_q.phase != PH_IDLE);
    assign done      = (r_q.phase == PH_FIN);
    assign buf_rd_en = (r_q.phase == PH_READ);
    assign buf_wr_en = (r_q.phase == PH_WRITE);
    assign buf_addr  = r_q.addr;
    assign buf_wdata = buf_rdata ^ (BYTE_W'(1) << r_q.bit_ix);
    assign status    = r_q.status;
endmodule

// File: rtl/hfix_chk.sv
module hfix_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       start,
    input logic       busy,
    input logic       done,
    input logic [1:0] status,
    input logic [8:0] buf_addr,
    input logic       buf_rd_en,
    input logic       buf_wr_en
);
    // R6
    read_then_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        buf_rd_en |=> buf_wr_en);
    // R6
    write_same_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        buf_rd_en |=> $stable(buf_addr));
    // R6
    write_gives_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        buf_wr_en |=> (done && status == 2'd1));
    // R9
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R11
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!buf_rd_en && !buf_wr_en && !done));
    // R10
    busy_start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done && start) |=> busy);
    // R7
    no_write_unless_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && status != 2'd1) |-> !$past(buf_wr_en));
endmodule

bind hamming_fix_unit hfix_chk u_hfix_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .busy      (busy),
    .done      (done),
    .status    (status),
    .buf_addr  (buf_addr),
    .buf_rd_en (buf_rd_en),
    .buf_wr_en (buf_wr_en)
);

// File: tb/sim_hamming_fix_unit.sv
module sim_hamming_fix_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [23:0] ecc_stored = '0;
    logic [23:0] ecc_calc = '0;
    logic        skip_erased = 1'b0;
    logic        busy, done, buf_rd_en, buf_wr_en;
    logic [1:0]  status;
    logic [8:0]  buf_addr;
    logic [7:0]  buf_rdata, buf_wdata;

    logic [7:0]  mem [512];
    logic [7:0]  ref_mem [512];

    int tests = 0;
    int fails = 0;
    int writes_seen = 0;
    int dones_seen = 0;
    int pushes = 0;
    bit finished = 0;

    typedef struct {
        logic [1:0] st;
        int         addr;
        logic [7:0] val;
        int         nwr;
        string      tag;
    } exp_t;
    exp_t sb[$];

    always #10 clk = ~clk;

    hamming_fix_unit u0 (
        .clk(clk), .rst_n(rst_n), .start(start),
        .ecc_stored(ecc_stored), .ecc_calc(ecc_calc), .skip_erased(skip_erased),
        .busy(busy), .done(done), .status(status),
        .buf_addr(buf_addr), .buf_rd_en(buf_rd_en), .buf_rdata(buf_rdata),
        .buf_wr_en(buf_wr_en), .buf_wdata(buf_wdata)
    );

    always @(posedge clk) begin
        if (buf_rd_en) buf_rdata <= mem[buf_addr];
        if (buf_wr_en) mem[buf_addr] <= buf_wdata;
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Monitor: compare each completion with the scoreboard head.
    always @(negedge clk) begin
        if (rst_n && buf_wr_en) writes_seen++;
        if (rst_n && done) begin
            exp_t e;
            dones_seen++;
            if (sb.size() == 0) begin
                check(0, "R10 unexpected done", 1, 0);
            end else begin
                e = sb.pop_front();
                check(status == e.st, {e.tag, " status"}, status, e.st);
                check(writes_seen == e.nwr, {e.tag, " writes"}, writes_seen, e.nwr);
            end
            writes_seen = 0;
        end
    end

    // Syndrome for a single data fault at byte b, bit k: odd bits hold the
    // location (R4, R5), even bits hold the complement (R3).
    function automatic logic [23:0] mk_syn(input int b, input int k);
        logic [11:0] loc;
        logic [23:0] s;
        loc = {k[2:0], b[8:0]};
        for (int p = 0; p < 12; p++) begin
            s[2*p+1] = loc[p];
            s[2*p]   = ~loc[p];
        end
        return s;
    endfunction

    task automatic run(input logic [23:0] st, input logic [23:0] ca, input bit sk,
                       input logic [1:0] exp_st, input int addr, input int bitk,
                       input string tag);
        exp_t e;
        int lat;
        if (exp_st == 2'd1) ref_mem[addr] = ref_mem[addr] ^ (8'd1 << bitk);
        e.st = exp_st; e.addr = addr; e.val = ref_mem[addr];
        e.nwr = (exp_st == 2'd1) ? 1 : 0; e.tag = tag;
        sb.push_back(e);
        pushes++;
        @(negedge clk);
        ecc_stored = st; ecc_calc = ca; skip_erased = sk; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 1;
        while (!done && lat < 10) begin
            @(negedge clk);
            lat++;
        end
        // R9: latency from start edge to done
        check(lat == ((exp_st == 2'd1) ? 3 : 1), {tag, " R9 latency"}, lat,
              (exp_st == 2'd1) ? 3 : 1);
        @(negedge clk);
        check(mem[addr] == e.val, {tag, " buffer byte"}, mem[addr], e.val);
        check(!busy && !done, {tag, " R9 back to idle"}, busy, 0);
    endtask

    initial begin
        for (int i = 0; i < 512; i++) begin
            mem[i] = 8'((i * 37 + 5) & 255);
            ref_mem[i] = mem[i];
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        check(!busy && !done && !buf_rd_en && !buf_wr_en && status == 2'd0,
              "R11 reset idle", {busy, done, buf_rd_en, buf_wr_en, status}, 0);

        // R1 identical codes
        run(24'h3C5A96, 24'h3C5A96, 1'b0, 2'd0, 10, 0, "R1 zero syndrome");
        // R2 erased page ignored with nonzero syndrome
        run(24'hFFFFFF, 24'h123456, 1'b1, 2'd0, 20, 0, "R2 erased skip");
        // R2 same with skip off: all-ones syndrome breaks every pair -> 3
        run(24'hFFFFFF, 24'h000000, 1'b0, 2'd3, 20, 0, "R2 erased no skip");
        // R4 R5 R6 corrections at corners
        run(24'h55AA33 ^ mk_syn(0, 0), 24'h55AA33, 1'b0, 2'd1, 0, 0, "R5 byte0 bit0");
        run(24'h0F0F0F ^ mk_syn(511, 7), 24'h0F0F0F, 1'b0, 2'd1, 511, 7, "R5 byte511 bit7");
        run(24'hA1B2C3 ^ mk_syn(256, 3), 24'hA1B2C3, 1'b0, 2'd1, 256, 3, "R4 byte256 bit3");
        run(24'h777777 ^ mk_syn(170, 5), 24'h777777, 1'b0, 2'd1, 170, 5, "R6 byte170 bit5");
        // R6 repairing the same bit again restores it
        run(24'h777777 ^ mk_syn(170, 5), 24'h777777, 1'b0, 2'd1, 170, 5, "R6 repeat flip");
        // R7 single syndrome bits at both ends
        run(24'h000001, 24'h000000, 1'b0, 2'd2, 1, 0, "R7 bit0");
        run(24'h800000, 24'h000000, 1'b0, 2'd2, 1, 0, "R7 bit23");
        // R3 one pair forced to 11 -> not correctable
        run(mk_syn(85, 2) | 24'h000C00, 24'h000000, 1'b0, 2'd3, 85, 0, "R3 bad pair");
        // R8 two-bit syndrome
        run(24'h000005, 24'h000000, 1'b0, 2'd3, 2, 0, "R8 two bits");

        // R10: extra start during a correction is ignored
        begin
            exp_t e;
            ref_mem[300] = ref_mem[300] ^ 8'h02;
            e.st = 2'd1; e.addr = 300; e.val = ref_mem[300]; e.nwr = 1;
            e.tag = "R10 busy start";
            sb.push_back(e); pushes++;
            @(negedge clk);
            ecc_stored = mk_syn(300, 1); ecc_calc = 24'h0; skip_erased = 0; start = 1;
            @(negedge clk);
            ecc_stored = 24'h000001;
            @(negedge clk);
            start = 0;
            repeat (5) @(negedge clk);
            check(mem[300] == e.val, "R10 buffer byte", mem[300], e.val);
            check(mem[0] == ref_mem[0], "R10 other byte untouched", mem[0], ref_mem[0]);
            check(dones_seen == pushes, "R10 completions", dones_seen, pushes);
            check(status == 2'd1, "R10 status held", status, 1);
        end

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            tests++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule